// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the control half of a transmit DMA. Software fills a ring of descriptors in shared memory, each eight bytes long: a packed status word at offset 0 and a buffer pointer at offset 4, so descriptor i lives at ring base plus 8*i. The engine reads descriptors through a 32-bit request/acknowledge master port. It reads the status word at the current index. If the ready flag is set, it also reads the pointer and hands the buffer address, the frame length and the per-frame option flags to a downstream frame sender.

When the sender reports completion, the engine writes the status word back with only the ready flag cleared. It raises an interrupt pulse if the descriptor asked for one, and moves to the next descriptor. A descriptor that is not ready is not consumed. The engine polls it again after a programmable pause. A per-descriptor wrap flag, or reaching the last allowed index, returns the ring to index 0. The ring base, the maximum descriptor count and the poll pause are inputs. Moving frame data is the job of the sender, not of this block.

Top module: `txbd_ring_engine`

## Requirements
- R1: After reset the index is 0, `mem_req_o`, `tx_valid_o`, `irq_o` and `err_o` are low, and no memory request is made while `en_i` is low.
- R2: The status word of descriptor i is read at `ring_base_i + 8*i` and its buffer pointer at `ring_base_i + 8*i + 4`.
- R3: When the status word has bit 15 (ready) set, the engine raises `tx_valid_o` with `tx_addr_o` equal to the pointer word and `tx_len_o` equal to status bits 31:16. `tx_flags_o` is {bit 14 interrupt request, bit 12 pad, bit 11 CRC}, passed through unchanged.
- R4: A descriptor with bit 15 clear is not consumed. The index stays the same, and the same status word is read again after `mem_req_o` has been low for exactly `poll_dly_i`+2 cycles.
- R5: On `tx_done_i`, the status word is written back to the same descriptor address with bit 15 cleared and every other bit unchanged.
- R6: After a successful write-back the index becomes 0 if status bit 13 (wrap) was set or the index equals `max_desc_i`-1. Otherwise it increments by 1.
- R7: `irq_o` pulses for exactly one cycle after a write-back completes, and only when status bit 14 of that descriptor was set.
- R8: While `mem_req_o` is high and neither `mem_ack_i` nor `mem_err_i` is seen, the request, address, write enable and write data stay unchanged.
- R9: `mem_err_i` aborts the current descriptor. It sets `err_o`, which stays high until reset. The index is not advanced, and the same descriptor is retried after the poll pause.
- R10: `tx_valid_o` stays high, with no memory request, until `tx_done_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Allows the engine to start descriptor accesses |
| ring_base_i | input | 32 | Byte address of descriptor 0 |
| max_desc_i | input | 8 | Number of descriptors in the ring (at least 1) |
| poll_dly_i | input | 8 | Pause length used when polling an idle descriptor |
| mem_req_o | output | 1 | Memory request, held until acknowledge or error |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access done; read data valid |
| mem_err_i | input | 1 | Access failed |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | A frame is handed to the sender |
| tx_addr_o | output | 32 | Buffer address of the frame |
| tx_len_o | output | 16 | Frame length |
| tx_flags_o | output | 3 | {interrupt request, pad, CRC} |
| tx_done_i | input | 1 | Sender finished the frame |
| irq_o | output | 1 | One-cycle completion interrupt |
| err_o | output | 1 | Sticky memory error status |
| idx_o | output | 7 | Current descriptor index |

## Verification
The assertions check the following on every cycle:
- the memory request stays stable until it is answered;
- the interrupt lasts only one cycle;
- the error status is sticky;
- the sender handshake holds until done, with the port quiet meanwhile;
- a write-back never carries the ready bit;
- the index only steps by one or returns to 0;
- the poll timer counts down one per cycle.

Only the bench scenarios can show the data-dependent results. These are the length, pointer and flag pass-through, and which index follows each combination of wrap flag and ring end. They also cover that the written-back word keeps every other bit, the exact poll gap, and that an error leaves the descriptor to be retried.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
  localparam int unsigned RDY_B  = 15;
  localparam int unsigned IRQ_B  = 14;
  localparam int unsigned WRAP_B = 13;
  localparam int unsigned PAD_B  = 12;
  localparam int unsigned CRC_B  = 11;
  localparam int unsigned LEN_LO = 16;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_STAT,
    S_RD_PTR,
    S_SEND,
    S_WR_STAT,
    S_WAIT
  } eng_state_t;
endpackage

// File: rtl/txbd_ring_index.sv
module txbd_ring_index #(
  parameter int IDX_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           adv_i,
  input  logic           wrap_i,
  input  logic [IDX_W:0] max_i,
  output logic [IDX_W-1:0] idx_o
);
  logic last;
  assign last = ({1'b0, idx_o} == (max_i - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) idx_o <= '0;
    else if (adv_i) idx_o <= (wrap_i || last) ? '0 : idx_o + 1'b1;
  end

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (idx_o != $past(idx_o)) |-> (idx_o == '0 || idx_o == $past(idx_o) + 1'b1)); // R6
endmodule

// File: rtl/txbd_poll_timer.sv
module txbd_poll_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             done_o
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load_i) cnt <= dly_i;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done_o = (cnt == '0);

  AST_TMR_DOWN: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) != '0 && !$past(load_i)) |-> (cnt == $past(cnt) - 1'b1)); // R4
endmodule

// File: rtl/txbd_ctrl.sv
module txbd_ctrl
  import txbd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              tmr_done_i,
  output logic              tmr_load_o,
  output logic              adv_o,
  output logic              wrap_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              tx_valid_o,
  output logic [ADDR_W-1:0] tx_addr_o,
  output logic [15:0]       tx_len_o,
  output logic [2:0]        tx_flags_o,
  input  logic              tx_done_i,
  output logic              irq_o,
  output logic              err_o
);
  localparam int PAD_W = ADDR_W - IDX_W - 3;

  eng_state_t  state;
  logic [31:0] status;
  logic [ADDR_W-1:0] desc_addr;

  assign desc_addr = ring_base_i + {{PAD_W{1'b0}}, idx_i, 3'b000};

  always_comb begin
    tmr_load_o = 1'b0;
    adv_o      = 1'b0;
    case (state)
      S_RD_STAT: tmr_load_o = mem_err_i || (mem_ack_i && !mem_rdata_i[RDY_B]);
      S_RD_PTR:  tmr_load_o = mem_err_i;
      S_WR_STAT: begin
        tmr_load_o = mem_err_i;
        adv_o      = mem_ack_i && !mem_err_i;
      end
      default: ;
    endcase
  end

  assign wrap_o     = status[WRAP_B];
  assign tx_len_o   = status[31:LEN_LO];
  assign tx_flags_o = {status[IRQ_B], status[PAD_B], status[CRC_B]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      status      <= '0;
      tx_valid_o  <= 1'b0;
      tx_addr_o   <= '0;
      irq_o       <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      case (state)
        S_IDLE: if (en_i) begin
          mem_req_o  <= 1'b1;
          mem_we_o   <= 1'b0;
          mem_addr_o <= desc_addr;
          state      <= S_RD_STAT;
        end
        S_RD_STAT: begin
          if (mem_err_i) begin
            mem_req_o <= 1'b0;
            err_o     <= 1'b1;
            state     <= S_WAIT;
          end else if (mem_ack_i) begin
            status <= mem_rdata_i;
            if (mem_rdata_i[RDY_B]) begin
              mem_addr_o <= mem_addr_o + 4;
              state      <= S_RD_PTR;
            end else begin
              mem_req_o <= 1'b0;
              state     <= S_WAIT;
            end
          end
        end
        S_RD_PTR: begin
          if (mem_err_i) begin
            mem_req_o <= 1'b0;
            err_o     <= 1'b1;
            state     <= S_WAIT;
          end else if (mem_ack_i) begin
            mem_req_o  <= 1'b0;
            tx_addr_o  <= mem_rdata_i[ADDR_W-1:0];
            tx_valid_o <= 1'b1;
            state      <= S_SEND;
          end
        end
        S_SEND: if (tx_done_i) begin
          tx_valid_o  <= 1'b0;
          mem_req_o   <= 1'b1;
          mem_we_o    <= 1'b1;
          mem_addr_o  <= desc_addr;
          mem_wdata_o <= status & ~(32'd1 << RDY_B);
          state       <= S_WR_STAT;
        end
        S_WR_STAT: begin
          if (mem_err_i) begin
            mem_req_o <= 1'b0;
            mem_we_o  <= 1'b0;
            err_o     <= 1'b1;
            state     <= S_WAIT;
          end else if (mem_ack_i) begin
            mem_req_o <= 1'b0;
            mem_we_o  <= 1'b0;
            irq_o     <= status[IRQ_B];
            state     <= S_IDLE;
          end
        end
        S_WAIT: if (tmr_done_i) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ack_i && !mem_err_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o))); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_o |=> err_o); // R9
  AST_TXV_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tx_valid_o && !tx_done_i) |=> tx_valid_o); // R10
  AST_QUIET_SEND: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> !mem_req_o); // R10
  AST_WB_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && mem_we_o) |-> !mem_wdata_o[RDY_B]); // R5
endmodule

// File: rtl/txbd_ring_engine.sv
module txbd_ring_engine #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7,
  parameter int DLY_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] ring_base_i,
  input  logic [IDX_W:0]    max_desc_i,
  input  logic [DLY_W-1:0]  poll_dly_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              tx_valid_o,
  output logic [ADDR_W-1:0] tx_addr_o,
  output logic [15:0]       tx_len_o,
  output logic [2:0]        tx_flags_o,
  input  logic              tx_done_i,
  output logic              irq_o,
  output logic              err_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic tmr_load, tmr_done, adv, wrap;

  txbd_ring_index #(.IDX_W(IDX_W)) u_index (
    .clk(clk), .rst(rst), .adv_i(adv), .wrap_i(wrap),
    .max_i(max_desc_i), .idx_o(idx_o)
  );

  txbd_poll_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .load_i(tmr_load), .dly_i(poll_dly_i),
    .done_o(tmr_done)
  );

  txbd_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .en_i(en_i), .ring_base_i(ring_base_i),
    .idx_i(idx_o), .tmr_done_i(tmr_done), .tmr_load_o(tmr_load),
    .adv_o(adv), .wrap_o(wrap),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i),
    .mem_rdata_i(mem_rdata_i),
    .tx_valid_o(tx_valid_o), .tx_addr_o(tx_addr_o), .tx_len_o(tx_len_o),
    .tx_flags_o(tx_flags_o), .tx_done_i(tx_done_i),
    .irq_o(irq_o), .err_o(err_o)
  );
endmodule

// File: tb/txbd_ring_engine_test.sv
module txbd_ring_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h20;
  localparam int MAXD = 4;
  localparam int DLY = 3;
  localparam logic [31:0] PTR0 = 32'h0001_0000;

  // {len[19:4], wrap, irq, pad, crc}
  localparam logic [19:0] VEC [7] = '{
    {16'h0364, 4'b0111},
    {16'h0234, 4'b0001},
    {16'h0534, 4'b1100},
    {16'h0040, 4'b0000},
    {16'h05EE, 4'b0110},
    {16'h0010, 4'b0010},
    {16'h0100, 4'b0101}
  };

  logic clk = 0, rst = 1, en = 0, tx_done = 0;
  logic mem_req, mem_we, mem_ack, mem_err, tx_valid, irq, err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, tx_addr;
  logic [15:0] tx_len;
  logic [2:0]  tx_flags;
  logic [6:0]  idx;

  logic [31:0] mem [64];
  logic        inj_en = 0;
  logic [31:0] inj_addr = 0;
  int lowcnt, last_gap, irq_cnt, req_rises;
  logic [31:0] last_rd_addr;
  logic req_q;
  int checks = 0, errors = 0;
  int exp_idx = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txbd_ring_engine uut (
    .clk(clk), .rst(rst), .en_i(en), .ring_base_i(BASE),
    .max_desc_i(8'(MAXD)), .poll_dly_i(8'(DLY)),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_err_i(mem_err),
    .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_addr_o(tx_addr), .tx_len_o(tx_len),
    .tx_flags_o(tx_flags), .tx_done_i(tx_done),
    .irq_o(irq), .err_o(err), .idx_o(idx)
  );

  // memory model: one-cycle latency answer
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 0; mem_err <= 0; mem_rdata <= 0;
    end else if (mem_req && !mem_ack && !mem_err) begin
      if (inj_en && mem_addr == inj_addr) mem_err <= 1;
      else begin
        mem_ack <= 1;
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        else mem_rdata <= mem[mem_addr[7:2]];
      end
    end else begin
      mem_ack <= 0; mem_err <= 0;
    end
  end

  // monitors
  always @(posedge clk) begin
    if (rst) begin
      lowcnt <= 0; last_gap <= 0; irq_cnt <= 0; req_rises <= 0;
      last_rd_addr <= 32'hFFFF_FFFF; req_q <= 0;
    end else begin
      req_q <= mem_req;
      if (!mem_req) lowcnt <= lowcnt + 1;
      else begin
        if (lowcnt != 0) last_gap <= lowcnt;
        lowcnt <= 0;
      end
      if (mem_req && !req_q) begin
        req_rises <= req_rises + 1;
        if (!mem_we && mem_addr[2] == 1'b0) last_rd_addr <= mem_addr;
      end
      if (irq) irq_cnt <= irq_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_txv(output bit seen);
    seen = 0;
    for (int t = 0; t < 300; t++) begin
      @(negedge clk);
      if (tx_valid) begin seen = 1; break; end
    end
  endtask

  task automatic run_vec(input int k);
    logic [19:0] v;
    logic [31:0] st, ptr;
    int irq0, nxt;
    bit seen;
    v = VEC[k];
    st = {v[19:4], 1'b1, v[2], v[3], v[1], v[0], 11'h05A};
    ptr = PTR0 + k * 32'h600;
    mem[8 + 2*exp_idx] = st;
    mem[9 + 2*exp_idx] = ptr;
    wait_txv(seen);
    chk(seen, "R3 frame offered", 32'(seen), 1);
    chk(tx_addr == ptr, "R3 buffer address", tx_addr, ptr);
    chk(tx_len == v[19:4], "R3 length", 32'(tx_len), 32'(v[19:4]));
    chk(tx_flags == {v[2], v[1], v[0]}, "R3 flags", 32'(tx_flags), 32'({v[2], v[1], v[0]}));
    cyc(3);
    chk(tx_valid && !mem_req, "R10 held until done", 32'(tx_valid), 1);
    irq0 = irq_cnt;
    tx_done = 1; cyc(1); tx_done = 0;
    cyc(12);
    chk(irq_cnt - irq0 == int'(v[2]), "R7 interrupt count", 32'(irq_cnt - irq0), 32'(v[2]));
    chk(mem[8 + 2*exp_idx] == (st & ~32'h8000), "R5 write-back", mem[8 + 2*exp_idx], st & ~32'h8000);
    nxt = (v[3] || exp_idx == MAXD - 1) ? 0 : exp_idx + 1;
    chk(idx == 7'(nxt), "R6 next index", 32'(idx), 32'(nxt));
    exp_idx = nxt;
  endtask

  initial begin
    bit seen;
    int r0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    cyc(3);
    rst = 0;
    cyc(1);
    chk(idx == 0 && !tx_valid && !irq && !err && !mem_req, "R1 reset state", {tx_valid, irq, err, mem_req}, 0);
    cyc(20);
    chk(req_rises == 0, "R1 no access while disabled", req_rises, 0);

    en = 1;
    cyc(40);
    chk(last_gap == DLY + 2, "R4 poll gap", last_gap, DLY + 2);
    chk(idx == 0 && !tx_valid, "R4 not consumed", 32'(idx), 0);
    chk(last_rd_addr == BASE, "R2 status address desc 0", last_rd_addr, BASE);

    for (int k = 0; k < 7; k++) run_vec(k);

    cyc(20);
    chk(last_rd_addr == BASE + 8 * exp_idx, "R2 status address after ring", last_rd_addr, BASE + 8 * exp_idx);

    // error on pointer read
    inj_addr = BASE + 8 * exp_idx + 4;
    inj_en = 1;
    mem[8 + 2*exp_idx] = {16'h0077, 1'b1, 15'h0};
    mem[9 + 2*exp_idx] = 32'h0000_ABC0;
    cyc(25);
    chk(err, "R9 error sticky set", 32'(err), 1);
    chk(!tx_valid && idx == 7'(exp_idx), "R9 descriptor aborted", 32'(idx), 32'(exp_idx));
    chk(last_rd_addr == BASE + 8 * exp_idx, "R9 same descriptor retried", last_rd_addr, BASE + 8 * exp_idx);
    inj_en = 0;
    wait_txv(seen);
    chk(seen && tx_addr == 32'h0000_ABC0, "R9 retry succeeds", tx_addr, 32'h0000_ABC0);
    tx_done = 1; cyc(1); tx_done = 0;
    cyc(12);
    chk(err, "R9 error stays set", 32'(err), 1);
    chk(idx == 7'(exp_idx + 1), "R6 advance after retry", 32'(idx), 32'(exp_idx + 1));

    // reset again
    rst = 1; en = 0; cyc(2); rst = 0; cyc(1);
    chk(!err && idx == 0 && !mem_req && !tx_valid, "R1 reset clears", {err, 1'b0, idx}, 0);
    r0 = req_rises;
    cyc(15);
    chk(req_rises == r0, "R1 idle without enable", req_rises, r0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done_flag = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule